// File: doc/BRIEF.md
# Programmable Access Timing Sequencer

This block sits between a memory-mapped master and one simple peripheral. It turns each master read or write into a strobed access on the peripheral side. Every access has three phases. In the setup phase chip select is on but neither strobe is active. In the strobe phase the read or write strobe is low. In the hold phase chip select stays on after the strobe has been released. The length of each phase comes from configuration inputs, and reads and writes have separate sets.

The master sees backpressure through a wait signal. It stays high until the cycle in which the access finishes. When all phase counts are zero, an access finishes in the cycle it is presented and the wait signal never rises. Read data is taken from the peripheral in the last strobe cycle. In the finishing cycle it is returned either straight through, when there is no hold, or from a register, when there is a hold.

The master must keep address, controls and write data steady while the wait signal is high. The block forwards address and write data to the peripheral without registering them. They are therefore stable on the peripheral side during setup, strobe and hold.

Top module: `xfer_phase_seq`

## Requirements
- R1: A read with read setup, wait and hold all zero finishes in the cycle it is presented. During that cycle `m_waitreq` is 0, `s_rd_n` is 0, and `m_rdata` equals `s_rdata`.
- R2: A transfer with setup count S first spends exactly S cycles with `s_cs`=1 and both strobes at 1. Only then does its strobe go low.
- R3: A transfer with wait count W keeps its strobe low for exactly W+1 consecutive cycles. A read drives only `s_rd_n` low and a write drives only `s_wr_n` low.
- R4: A write with write setup, wait and hold all zero finishes in a single cycle. In that cycle `s_wr_n` is 0 and `m_waitreq` is 0.
- R5: A transfer with hold count H keeps `s_cs`=1 with both strobes at 1 for exactly H cycles after its strobe rises. Throughout these cycles `s_addr` and `s_wdata` equal the master's address and write data.
- R6: `m_waitreq` is 1 in every cycle of a transfer except the last. A transfer lasts S+1+W+H cycles.
- R7: Reads are timed only by `rd_setup`/`rd_wait`/`rd_hold`, and writes only by `wr_setup`/`wr_wait`/`wr_hold`.
- R8: The read data returned in the finishing cycle is the value `s_rdata` had in the last strobe cycle, even if `s_rdata` changes during the hold phase.
- R9: A request presented in the cycle after a transfer finishes starts at once. No new strobe appears while an earlier transfer is still in its hold phase.
- R10: During and after reset, with no request, `s_cs`=0, `s_rd_n`=1, `s_wr_n`=1 and `m_waitreq`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rd_setup | input | CNT_W | Read setup cycles |
| rd_wait | input | CNT_W | Extra read strobe cycles |
| rd_hold | input | CNT_W | Read hold cycles |
| wr_setup | input | CNT_W | Write setup cycles |
| wr_wait | input | CNT_W | Extra write strobe cycles |
| wr_hold | input | CNT_W | Write hold cycles |
| m_addr | input | ADDR_W | Master address |
| m_read | input | 1 | Master read request |
| m_write | input | 1 | Master write request |
| m_wdata | input | DATA_W | Master write data |
| m_rdata | output | DATA_W | Read data to master, valid in the finishing cycle |
| m_waitreq | output | 1 | Backpressure to master |
| s_cs | output | 1 | Peripheral chip select, active high |
| s_rd_n | output | 1 | Peripheral read strobe, active low |
| s_wr_n | output | 1 | Peripheral write strobe, active low |
| s_addr | output | ADDR_W | Peripheral address |
| s_wdata | output | DATA_W | Peripheral write data |
| s_rdata | input | DATA_W | Peripheral read data |

## Verification
The bench builds the block with CNT_W=2, ADDR_W=8 and DATA_W=8. The 2-bit counts make the whole configuration space small enough to sweep. Every setup, wait and hold combination from 0 to 3 is run for both reads and writes, with the unused direction's set loaded with different values. That sweep covers the zero-length single-cycle cases and the longest phases, where the counter reaches its top value. Because the peripheral read data changes every cycle, a read with a hold phase shows whether the returned value comes from the last strobe cycle.

// File: rtl/xps_pkg.sv
package xps_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_STROBE = 2'd2,
    PH_HOLD   = 2'd3
  } phase_e;
endpackage

// File: rtl/xps_phase_ctrl.sv
module xps_phase_ctrl
  import xps_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_rd,
  input  logic             req_wr,
  input  logic [CNT_W-1:0] rd_setup,
  input  logic [CNT_W-1:0] rd_wait,
  input  logic [CNT_W-1:0] rd_hold,
  input  logic [CNT_W-1:0] wr_setup,
  input  logic [CNT_W-1:0] wr_wait,
  input  logic [CNT_W-1:0] wr_hold,
  output phase_e           phase,
  output logic             dir_wr,
  output logic             strobe_last,
  output logic             waitreq
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  phase_e           state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt;
  logic             dir_q;
  logic [CNT_W-1:0] setup_n, wait_n, hold_n;
  logic             ph_end, last, adv;

  // effective phase of the current cycle (a request starts combinationally)
  always_comb begin
    dir_wr  = (state_q == PH_IDLE) ? req_wr : dir_q;
    setup_n = dir_wr ? wr_setup : rd_setup;
    wait_n  = dir_wr ? wr_wait  : rd_wait;
    hold_n  = dir_wr ? wr_hold  : rd_hold;
    if (state_q == PH_IDLE) begin
      cnt = '0;
      if (req_rd || req_wr) phase = (setup_n != '0) ? PH_SETUP : PH_STROBE;
      else                  phase = PH_IDLE;
    end else begin
      cnt   = cnt_q;
      phase = state_q;
    end
  end

  always_comb begin
    case (phase)
      PH_SETUP:  ph_end = (cnt == setup_n - ONE);
      PH_STROBE: ph_end = (cnt == wait_n);
      PH_HOLD:   ph_end = (cnt == hold_n - ONE);
      default:   ph_end = 1'b0;
    endcase
    last        = (phase == PH_STROBE && ph_end && hold_n == '0) ||
                  (phase == PH_HOLD && ph_end);
    strobe_last = (phase == PH_STROBE) && ph_end;
    waitreq     = (phase != PH_IDLE) && !last;
    adv         = (phase != PH_IDLE);
  end

  // next-state
  always_comb begin
    state_d = phase;
    cnt_d   = cnt + ONE;
    if (ph_end) begin
      cnt_d = '0;
      case (phase)
        PH_SETUP:  state_d = PH_STROBE;
        PH_STROBE: state_d = (hold_n != '0) ? PH_HOLD : PH_IDLE;
        default:   state_d = PH_IDLE;
      endcase
    end
    if (phase == PH_IDLE) begin
      state_d = PH_IDLE;
      cnt_d   = '0;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PH_IDLE;
      cnt_q   <= '0;
      dir_q   <= 1'b0;
    end else if (adv) begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      dir_q   <= dir_wr;
    end
  end

  AST_SETUP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PH_SETUP) |-> (cnt_q < setup_n)); // R2
  AST_STROBE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PH_STROBE) |-> (cnt_q <= wait_n)); // R3
  AST_HOLD_FOLLOWS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PH_HOLD && cnt_q == '0) |-> ($past(phase) == PH_STROBE)); // R5
endmodule

// File: rtl/xps_rd_capture.sv
module xps_rd_capture #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic              in_strobe,
  input  logic [DATA_W-1:0] s_rdata,
  output logic [DATA_W-1:0] m_rdata
);
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (cap_en) rdata_q <= s_rdata;
  end

  assign m_rdata = in_strobe ? s_rdata : rdata_q;

  AST_CAPTURE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cap_en) && !in_strobe |-> (m_rdata == $past(s_rdata))); // R8
endmodule

// File: rtl/xfer_phase_seq.sv
module xfer_phase_seq
  import xps_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  rd_setup,
  input  logic [CNT_W-1:0]  rd_wait,
  input  logic [CNT_W-1:0]  rd_hold,
  input  logic [CNT_W-1:0]  wr_setup,
  input  logic [CNT_W-1:0]  wr_wait,
  input  logic [CNT_W-1:0]  wr_hold,
  input  logic [ADDR_W-1:0] m_addr,
  input  logic              m_read,
  input  logic              m_write,
  input  logic [DATA_W-1:0] m_wdata,
  output logic [DATA_W-1:0] m_rdata,
  output logic              m_waitreq,
  output logic              s_cs,
  output logic              s_rd_n,
  output logic              s_wr_n,
  output logic [ADDR_W-1:0] s_addr,
  output logic [DATA_W-1:0] s_wdata,
  input  logic [DATA_W-1:0] s_rdata
);
  logic   rst_meta, rst_sync;
  phase_e phase;
  logic   dir_wr, strobe_last, in_strobe;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  xps_phase_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_sync),
    .req_rd     (m_read),
    .req_wr     (m_write),
    .rd_setup   (rd_setup),
    .rd_wait    (rd_wait),
    .rd_hold    (rd_hold),
    .wr_setup   (wr_setup),
    .wr_wait    (wr_wait),
    .wr_hold    (wr_hold),
    .phase      (phase),
    .dir_wr     (dir_wr),
    .strobe_last(strobe_last),
    .waitreq    (m_waitreq)
  );

  assign in_strobe = (phase == PH_STROBE);

  xps_rd_capture #(.DATA_W(DATA_W)) u_cap (
    .clk      (clk),
    .rst_n    (rst_sync),
    .cap_en   (strobe_last && !dir_wr),
    .in_strobe(in_strobe),
    .s_rdata  (s_rdata),
    .m_rdata  (m_rdata)
  );

  assign s_cs    = (phase != PH_IDLE);
  assign s_rd_n  = !(in_strobe && !dir_wr);
  assign s_wr_n  = !(in_strobe && dir_wr);
  assign s_addr  = m_addr;
  assign s_wdata = m_wdata;

  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_sync)
    !(m_read || m_write) |-> (!s_cs && s_rd_n && s_wr_n && !m_waitreq)); // R10
  AST_WR_STROBE_ONLY_WRITE: assert property (@(posedge clk) disable iff (!rst_sync)
    !s_wr_n |-> (m_write && s_rd_n)); // R3
  AST_MASTER_HELD: assert property (@(posedge clk) disable iff (!rst_sync)
    m_waitreq |=> ($stable(m_addr) && $stable(m_wdata) && $stable(m_read) && $stable(m_write))); // R5
  AST_WAIT_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_sync)
    m_waitreq |-> s_cs); // R6
endmodule

// File: tb/xfer_phase_seq_test.sv
module xfer_phase_seq_test;
  localparam int AW = 8, DW = 8, CW = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic [CW-1:0] rd_setup, rd_wait, rd_hold, wr_setup, wr_wait, wr_hold;
  logic [AW-1:0] m_addr, s_addr;
  logic m_read, m_write, m_waitreq, s_cs, s_rd_n, s_wr_n;
  logic [DW-1:0] m_wdata, m_rdata, s_wdata, s_rdata;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  xfer_phase_seq #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n),
    .rd_setup(rd_setup), .rd_wait(rd_wait), .rd_hold(rd_hold),
    .wr_setup(wr_setup), .wr_wait(wr_wait), .wr_hold(wr_hold),
    .m_addr(m_addr), .m_read(m_read), .m_write(m_write), .m_wdata(m_wdata),
    .m_rdata(m_rdata), .m_waitreq(m_waitreq),
    .s_cs(s_cs), .s_rd_n(s_rd_n), .s_wr_n(s_wr_n),
    .s_addr(s_addr), .s_wdata(s_wdata), .s_rdata(s_rdata)
  );

  // {write, setup, wait, hold, expected total cycles}
  localparam logic [10:0] VEC [8] = '{
    {1'b0, 2'd0, 2'd0, 2'd0, 4'd1},
    {1'b0, 2'd1, 2'd1, 2'd0, 4'd3},
    {1'b0, 2'd3, 2'd3, 2'd3, 4'd10},
    {1'b1, 2'd0, 2'd0, 2'd0, 4'd1},
    {1'b1, 2'd1, 2'd0, 2'd1, 4'd3},
    {1'b1, 2'd2, 2'd3, 2'd1, 4'd7},
    {1'b0, 2'd0, 2'd2, 2'd3, 4'd6},
    {1'b1, 2'd3, 2'd0, 2'd0, 4'd4}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic go_idle();
    @(negedge clk);
    m_read  = 1'b0;
    m_write = 1'b0;
  endtask

  // runs one transfer starting at the next falling edge, ends in its last cycle
  task automatic xfer(input bit wr, input int s, input int w, input int h,
                      input bit await_edge, output int ok_all);
    int ns = 0, nst = 0, nh = 0, k = 0, last_rd = 0;
    bool_t: begin end
    ok_all = 1;
    if (await_edge) @(negedge clk);
    wr_setup = wr ? CW'(s) : CW'(3 - s);
    wr_wait  = wr ? CW'(w) : CW'(3 - w);
    wr_hold  = wr ? CW'(h) : CW'(3 - h);
    rd_setup = wr ? CW'(3 - s) : CW'(s);
    rd_wait  = wr ? CW'(3 - w) : CW'(w);
    rd_hold  = wr ? CW'(3 - h) : CW'(h);
    m_addr   = AW'(8'h40 + s * 16 + w * 4 + h);
    m_wdata  = DW'(8'h90 + s + w * 4 + h * 16);
    m_write  = wr;
    m_read   = !wr;
    forever begin
      s_rdata = DW'(8'hA0 + k * 7);
      #1;
      if (!s_rd_n || !s_wr_n) begin
        nst++;
        last_rd = int'(s_rdata);
        if (wr ? (!s_rd_n) : (!s_wr_n)) begin
          check(0, "R3 strobe kind", wr, 32'(!wr));
          ok_all = 0;
        end
      end else if (s_cs) begin
        if (nst > 0) nh++; else ns++;
      end
      if (s_cs && (s_addr != m_addr || s_wdata != m_wdata)) begin
        check(0, "R5 addr/data stable", int'(s_addr), int'(m_addr));
        ok_all = 0;
      end
      if (!m_waitreq) break;
      if (k > 40) break;
      @(negedge clk);
      k++;
    end
    check(ns == s,      wr ? "R2/R7 write setup" : "R2/R7 read setup",   ns,  s);
    check(nst == w + 1, wr ? "R3/R7 write strobe" : "R3/R7 read strobe", nst, w + 1);
    check(nh == h,      wr ? "R5/R7 write hold" : "R5/R7 read hold",     nh,  h);
    check(k + 1 == s + 1 + w + h, "R6 total cycles", k + 1, s + 1 + w + h);
    if (!wr) check(int'(m_rdata) == last_rd, "R8 read data", int'(m_rdata), last_rd);
    if (ns != s || nst != w + 1 || nh != h) ok_all = 0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int ok;
    rst_n = 1'b0;
    m_read = 1'b0; m_write = 1'b0;
    m_addr = '0; m_wdata = '0; s_rdata = '0;
    {rd_setup, rd_wait, rd_hold, wr_setup, wr_wait, wr_hold} = '0;

    // R10: reset state
    repeat (3) @(negedge clk);
    #1;
    check(!s_cs && s_rd_n && s_wr_n && !m_waitreq, "R10 in reset",
          int'({s_cs, s_rd_n, s_wr_n, m_waitreq}), 32'b0110);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check(!s_cs && s_rd_n && s_wr_n && !m_waitreq, "R10 after reset",
          int'({s_cs, s_rd_n, s_wr_n, m_waitreq}), 32'b0110);

    // table of representative vectors
    foreach (VEC[i]) begin
      xfer(VEC[i][10], int'(VEC[i][9:8]), int'(VEC[i][7:6]), int'(VEC[i][5:4]), 1'b1, ok);
      check(int'(VEC[i][3:0]) == int'(VEC[i][9:8]) + 1 + int'(VEC[i][7:6]) + int'(VEC[i][5:4]),
            "R6 table total", int'(VEC[i][3:0]), 0);
      go_idle();
    end

    // R1: zero-length read completes with no wait, data passes through
    @(negedge clk);
    {rd_setup, rd_wait, rd_hold} = '0;
    m_addr = 8'h11; s_rdata = 8'h5C; m_read = 1'b1;
    #1;
    check(!m_waitreq && !s_rd_n && m_rdata == 8'h5C, "R1 single cycle read",
          int'(m_rdata), 32'h5C);
    go_idle();

    // R4: zero-length write
    @(negedge clk);
    {wr_setup, wr_wait, wr_hold} = '0;
    m_wdata = 8'h3D; m_write = 1'b1;
    #1;
    check(!m_waitreq && !s_wr_n && s_wdata == 8'h3D, "R4 single cycle write",
          int'({m_waitreq, s_wr_n}), 0);
    go_idle();

    // R9: write with hold, then a read right after completion
    xfer(1'b1, 0, 0, 2, 1'b1, ok);
    @(negedge clk);
    {rd_setup, rd_wait, rd_hold} = '0;
    m_write = 1'b0; m_read = 1'b1; s_rdata = 8'h77;
    #1;
    check(!s_rd_n && !m_waitreq && m_rdata == 8'h77, "R9 back-to-back start",
          int'({s_rd_n, m_waitreq}), 0);
    go_idle();

    // full sweep of phase counts, both directions
    for (int wr = 0; wr < 2; wr++)
      for (int s = 0; s < 4; s++)
        for (int w = 0; w < 4; w++)
          for (int h = 0; h < 4; h++) begin
            xfer(wr[0], s, w, h, 1'b1, ok);
            go_idle();
          end

    @(negedge clk);
    #1;
    check(!s_cs && !m_waitreq, "R10 idle at end", int'({s_cs, m_waitreq}), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule